// File: doc/BRIEF.md
# Upper Memory RAM/ROM Overlay Controller

This block steers the top 12 KB of an 8-bit CPU's 64 KB address space (D000-FFFF) between a fixed ROM image and a 16 KB expansion RAM. The CPU selects the mapping by reading one of sixteen control addresses in C080-C08F. Each such read loads three mode bits: which of two 4 KB banks backs D000-DFFF, whether reads in the window come from RAM or from ROM, and whether writes in the window reach the RAM.

For every access that falls in the window, the block flags the access as hit. It raises a RAM-read or ROM-read select, or a RAM write enable, and it drives the physical offsets into the RAM and into the ROM. The RAM and ROM arrays sit outside the block. The select and offset outputs are combinational from the current bus address and the registered mode. A mode change therefore takes effect from the access that follows the control read.

Physical RAM layout: bank 1 occupies offsets 0000-0FFF, bank 2 occupies 1000-1FFF, and the shared 8 KB region for E000-FFFF occupies 2000-3FFF.

Top module: `upram_ctrl`

## Requirements
- R1: A synchronous active-low reset selects ROM reads, disables RAM writes and selects bank 1. After reset, a read of D000 raises the ROM select, and a write to D000 leaves ram_we low.
- R2: A read of C080-C08F loads the mode at the next rising edge. Offset bit 3 picks the bank: a value of 0 selects bank 2 and a value of 1 selects bank 1.
- R3: After a control read, the low offset bits decide where window reads come from. Bits [1:0] of 00 or 11 make them come from RAM (rd_sel_ram high). Bits [1:0] of 01 or 10 make them come from ROM (rd_sel_rom high).
- R4: After a control read, offset bit 0 decides whether window writes reach the RAM. A value of 1 enables them, so a window write raises ram_we. A value of 0 disables them, so window writes leave ram_we low.
- R5: Offset bit 2 has no effect. Offsets 4-7 act exactly as 0-3, and C-F act exactly as 8-B.
- R6: A write to C080-C08F, and any access outside C080-C08F, leaves the mode unchanged.
- R7: For a D000-DFFF access, ram_ofs is address[11:0] plus 0000 in bank 1, or plus 1000 in bank 2.
- R8: For an E000-FFFF access, ram_ofs is 2000 plus (address - E000), whatever bank is selected.
- R9: For a window access, rom_ofs is address - C000, so D000-FFFF maps onto the top 12 KB of the 16 KB ROM image.
- R10: For an access outside D000-FFFF, or with no strobe, win_hit, rd_sel_ram, rd_sel_rom and ram_we are low and both offsets are zero.
- R11: rd_sel_ram and rd_sel_rom are never high together, and neither is raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address of the current access |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_wr | input | 1 | Write strobe for the current cycle |
| win_hit | output | 1 | Current access falls in D000-FFFF |
| rd_sel_ram | output | 1 | Window read is served by expansion RAM |
| rd_sel_rom | output | 1 | Window read is served by ROM |
| ram_we | output | 1 | Window write is committed to expansion RAM |
| ram_ofs | output | 14 | Physical offset into the 16 KB RAM |
| rom_ofs | output | 14 | Physical offset into the 16 KB ROM image |

## Verification
Two events can meet at the same clock edge: a control read loading a new mode, and the mapping of the window access issued in the very next cycle. The mapping of that next access must already use the new mode, not the old one.

The bench provokes this with back-to-back sequences: a control read followed at once by a D000, E000 or FFFF read or write. The random stream also mixes control and window addresses densely. Each window access is judged against a bench-side mode model that updates at the same edge as the design.

// File: rtl/upram_pkg.sv
// Shared types for the upper-memory overlay controller.
// Assumes one bus access per cycle, marked by a read or a write strobe.
package upram_pkg;

    // Mode bits loaded by a control read.
    typedef struct packed {
        logic bank2;   // 1: D000-DFFF uses bank 2, 0: bank 1
        logic rd_ram;  // 1: window reads come from RAM
        logic wr_en;   // 1: window writes reach RAM
    } upram_mode_t;

    localparam upram_mode_t MODE_RESET = '{bank2: 1'b0, rd_ram: 1'b0, wr_en: 1'b0};

endpackage

// File: rtl/upram_mode_reg.sv
// Decodes reads of the sixteen control addresses and holds the overlay mode.
// Assumes: the control page is the address with its low 4 bits removed.
// Address bit 2 is not decoded, and writes to the control page do nothing.
module upram_mode_reg
    import upram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-5:0] SW_PAGE = 12'hC08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output upram_mode_t       mode_q
);

    logic        sw_hit;
    upram_mode_t mode_d;

    // Detect a read of the control page and derive the new mode from its offset.
    always_comb begin
        sw_hit        = bus_rd && (bus_addr[ADDR_W-1:4] == SW_PAGE);
        mode_d.bank2  = ~bus_addr[3];
        mode_d.rd_ram = ~(bus_addr[1] ^ bus_addr[0]);
        mode_d.wr_en  = bus_addr[0];
    end

    // Mode register: reset to ROM read, writes off, bank 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
        end else if (sw_hit) begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/upram_map.sv
// Maps a bus access in the top window onto RAM/ROM selects and offsets.
// Assumes: the window is the top three pages of BANK_AW bits each.
// The lowest of these pages is banked and the upper two are shared.
// RAM layout: bank 1, then bank 2, then the shared region.
module upram_map
    import upram_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_AW = 12,
    localparam int OFS_W  = BANK_AW + 2,
    localparam int PAGE_W = ADDR_W - BANK_AW
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  upram_mode_t       mode,
    output logic              win_hit,
    output logic              rd_sel_ram,
    output logic              rd_sel_rom,
    output logic              ram_we,
    output logic [OFS_W-1:0]  ram_ofs,
    output logic [OFS_W-1:0]  rom_ofs
);

    localparam logic [PAGE_W-1:0] BANKED_PAGE = {PAGE_W{1'b1}} - 2;

    logic [PAGE_W-1:0] page;
    logic              in_win;
    logic              banked;

    // Classify the page of the current address.
    always_comb begin
        page   = bus_addr[ADDR_W-1:BANK_AW];
        in_win = (page >= BANKED_PAGE);
        banked = (page == BANKED_PAGE);
    end

    // Produce the selects and offsets for the current access.
    always_comb begin
        win_hit    = in_win && (bus_rd || bus_wr);
        rd_sel_ram = win_hit && bus_rd && mode.rd_ram;
        rd_sel_rom = win_hit && bus_rd && !mode.rd_ram;
        ram_we     = win_hit && bus_wr && !bus_rd && mode.wr_en;
        ram_ofs    = '0;
        rom_ofs    = '0;
        if (win_hit) begin
            rom_ofs = bus_addr[OFS_W-1:0];
            if (banked) begin
                ram_ofs = {1'b0, mode.bank2, bus_addr[BANK_AW-1:0]};
            end else begin
                ram_ofs = {1'b1, bus_addr[BANK_AW:0]};
            end
        end
    end

endmodule

// File: rtl/upram_ctrl.sv
// Top of the upper-memory overlay controller: control decode plus window mapping.
// Assumes: bus_rd and bus_wr are not asserted together. If both are high, the
// access is treated as a read.
module upram_ctrl
    import upram_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_AW = 12,
    parameter logic [ADDR_W-5:0] SW_PAGE = 12'hC08,
    localparam int OFS_W  = BANK_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              win_hit,
    output logic              rd_sel_ram,
    output logic              rd_sel_rom,
    output logic              ram_we,
    output logic [OFS_W-1:0]  ram_ofs,
    output logic [OFS_W-1:0]  rom_ofs
);

    upram_mode_t mode_q;

    upram_mode_reg #(
        .ADDR_W (ADDR_W),
        .SW_PAGE(SW_PAGE)
    ) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_addr(bus_addr),
        .bus_rd  (bus_rd),
        .mode_q  (mode_q)
    );

    upram_map #(
        .ADDR_W (ADDR_W),
        .BANK_AW(BANK_AW)
    ) map_i (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .mode      (mode_q),
        .win_hit   (win_hit),
        .rd_sel_ram(rd_sel_ram),
        .rd_sel_rom(rd_sel_rom),
        .ram_we    (ram_we),
        .ram_ofs   (ram_ofs),
        .rom_ofs   (rom_ofs)
    );

endmodule

// File: rtl/upram_ctrl_chk.sv
// Property checker for upram_ctrl, attached to it by bind.
// Assumes the default 16-bit address and 4 KB bank geometry.
module upram_ctrl_chk
    import upram_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        win_hit,
    input logic        rd_sel_ram,
    input logic        rd_sel_rom,
    input logic        ram_we,
    input logic [13:0] ram_ofs,
    input upram_mode_t mode_q
);

    p_reset_mode_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_RESET));

    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[15:4] == 12'hC08) |=> (mode_q.bank2 == !$past(bus_addr[3])));

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr[15:4] == 12'hC08) |=> $stable(mode_q));

    p_we_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (mode_q.wr_en && bus_wr && win_hit));

    p_sel_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_sel_ram && rd_sel_rom) && !((rd_sel_ram || rd_sel_rom) && !bus_rd));

    p_outside_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:12] < 4'hD) |-> !(win_hit || ram_we || rd_sel_ram || rd_sel_rom));

    p_banked_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && bus_addr[15:12] == 4'hD) |-> (ram_ofs[13] == 1'b0 && ram_ofs[12] == mode_q.bank2));

    p_shared_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && bus_addr[15:13] == 3'b111) |-> (ram_ofs[13] == 1'b1));

endmodule

bind upram_ctrl upram_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .win_hit   (win_hit),
    .rd_sel_ram(rd_sel_ram),
    .rd_sel_rom(rd_sel_rom),
    .ram_we    (ram_we),
    .ram_ofs   (ram_ofs),
    .mode_q    (mode_q)
);

// File: tb/upram_ctrl_tb_top.sv
// Self-checking bench for upram_ctrl: directed corners plus seeded random traffic.
module upram_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        win_hit, rd_sel_ram, rd_sel_rom, ram_we;
    logic [13:0] ram_ofs, rom_ofs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side mode model.
    logic m_bank2 = 1'b0;
    logic m_rd    = 1'b0;
    logic m_wr    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    upram_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .win_hit   (win_hit),
        .rd_sel_ram(rd_sel_ram),
        .rd_sel_rom(rd_sel_rom),
        .ram_we    (ram_we),
        .ram_ofs   (ram_ofs),
        .rom_ofs   (rom_ofs)
    );

    function automatic logic [13:0] exp_ram(input logic [15:0] a, input logic b2);
        logic [15:0] v;
        if (a[15:12] == 4'hD) v = (b2 ? 16'h1000 : 16'h0000) + (a & 16'h0FFF);
        else                  v = 16'h2000 + (a - 16'hE000);
        return v[13:0];
    endfunction

    function automatic logic [13:0] exp_rom(input logic [15:0] a);
        logic [15:0] v;
        v = a - 16'hC000;
        return v[13:0];
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one access, check outputs mid-cycle, then advance the model at the edge.
    task automatic access(input logic [15:0] a, input logic r, input logic w, input string tag);
        logic hit;
        string t;
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w;
        #2;
        hit = (r || w) && (a >= 16'hD000);
        t = hit ? tag : {tag, "/R10"};
        chk(t, "win_hit", {15'd0, win_hit}, {15'd0, hit});
        chk({t, "/R3"}, "rd_sel_ram", {15'd0, rd_sel_ram}, {15'd0, hit && r && m_rd});
        chk({t, "/R3"}, "rd_sel_rom", {15'd0, rd_sel_rom}, {15'd0, hit && r && !m_rd});
        chk({t, "/R4"}, "ram_we", {15'd0, ram_we}, {15'd0, hit && w && !r && m_wr});
        chk({t, (a[15:12] == 4'hD) ? "/R7" : "/R8"}, "ram_ofs",
            {2'd0, ram_ofs}, {2'd0, hit ? exp_ram(a, m_bank2) : 14'd0});
        chk({t, "/R9"}, "rom_ofs", {2'd0, rom_ofs}, {2'd0, hit ? exp_rom(a) : 14'd0});
        @(posedge clk);
        if (rst_n && r && a[15:4] == 12'hC08) begin
            m_bank2 = ~a[3];
            m_rd    = (a[1:0] == 2'b00) || (a[1:0] == 2'b11);
            m_wr    = a[0];
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] a;
        int unsigned sel;
        sel = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state is ROM read, writes off.
        access(16'hD000, 1'b1, 1'b0, "R1");
        access(16'hD000, 1'b0, 1'b1, "R1");

        // R2/R3/R4/R5: every control offset followed at once by window accesses.
        for (int k = 0; k < 16; k++) begin
            access(16'hC080 + 16'(k), 1'b1, 1'b0, (k[2]) ? "R5" : "R2");
            access(16'hD123, 1'b1, 1'b0, "R2");
            access(16'hDFFF, 1'b0, 1'b1, "R4");
            access(16'hE000, 1'b1, 1'b0, "R8");
            access(16'hFFFF, 1'b0, 1'b1, "R8");
        end

        // R6: writes to the control page and other reads leave the mode alone.
        access(16'hC08B, 1'b1, 1'b0, "R6");
        access(16'hC080, 1'b0, 1'b1, "R6");
        access(16'hC09A, 1'b1, 1'b0, "R6");
        access(16'hC07F, 1'b1, 1'b0, "R6");
        access(16'hD800, 1'b1, 1'b0, "R6");
        access(16'hD800, 1'b0, 1'b1, "R6");

        // R10 and R11: window edges and idle cycles.
        access(16'hCFFF, 1'b1, 1'b0, "R10");
        access(16'hCFFF, 1'b0, 1'b1, "R10");
        access(16'hD000, 1'b0, 1'b0, "R10");
        access(16'hC083, 1'b1, 1'b0, "R7");
        access(16'hD000, 1'b1, 1'b0, "R7");
        access(16'hD000, 1'b0, 1'b1, "R11");

        // Seeded random mix biased toward control and window addresses.
        for (int n = 0; n < 3000; n++) begin
            sel = $urandom % 4;
            case (sel)
                0: a = 16'hC080 | 16'($urandom % 16);
                1: a = 16'hD000 | 16'($urandom % 16'h1000);
                2: a = 16'hE000 | 16'($urandom % 16'h2000);
                default: a = 16'($urandom);
            endcase
            sel = $urandom % 3;
            access(a, sel == 0 || (sel == 2 && a[4]), sel == 1, "RND");
        end

        finish_run();
    end

endmodule